// File: doc/BRIEF.md
# Pipelined Bus Slave Memory with Wait States

This block is a single-master AHB-Lite slave in front of a small word-organised memory. It samples address and control while the master presents them and performs the read or write in the data phase that follows. Because the next transfer's address phase overlaps the current data phase, the block registers the control it needs and can accept a new transfer in the same cycle that it completes the current one.

A parameter sets how many wait states, from 0 to 3, are inserted into each legal transfer. During those cycles the ready output is held low, and the master keeps both the pending address phase and the write data stable. Idle and busy cycles, and cycles in which the slave is not selected, get an OKAY response with no wait. An address outside the window, or a transfer size wider than the 32-bit bus, gets a two-cycle ERROR response and leaves the memory untouched.

Top module: `wait_bus_slave`

## Requirements
- R1: After reset `ready_out` is 1, `resp` is 0 and `rdata` is 0.
- R2: A cycle with `ready_in` high in which `sel` is low, or in which `trans` is IDLE (2'b00) or BUSY (2'b01), starts no access. The next cycle has `ready_out`=1 and `resp`=0, and the memory is unchanged even if `write` is high.
- R3: A transfer is accepted when `sel` and `ready_in` are high and `trans` is NONSEQ (2'b10) or SEQ (2'b11). For an in-range, legal-size transfer, `ready_out` is low for exactly WAIT_STATES cycles of the data phase and then high for one cycle with `resp`=0.
- R4: A write stores the byte lanes chosen by `size` and `addr[1:0]`. Size 3'd0 writes the single lane `addr[1:0]`. Size 3'd1 writes lanes 3:2 when `addr[1]` is 1 and lanes 1:0 otherwise. Size 3'd2 writes all four lanes. Lane k of `wdata` (bits 8k+7:8k) goes to byte k of the word, and the other bytes are kept. `wdata` is taken in the last cycle of the data phase.
- R5: A read returns the whole 32-bit word at word index (addr-BASE)/4 on `rdata` in the data-phase cycle where `ready_out` is high.
- R6: An accepted transfer with an address below BASE, or at or above BASE+4*DEPTH, gets an ERROR response. The first cycle has `ready_out`=0 and `resp`=1, and the second has `ready_out`=1 and `resp`=1. No memory word changes.
- R7: An accepted transfer with `size` from 3'd3 to 3'd7 gets the same two-cycle ERROR response as in R6 and performs no write.
- R8: Back-to-back transfers are handled. The next transfer is accepted in the same cycle that the current data phase completes, and an address phase held during wait states is accepted only once. A read that directly follows a write to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Slave select for the address phase |
| addr | input | 32 | Byte address of the address phase |
| trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| write | input | 1 | 1 for write, 0 for read |
| size | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Write data for the current data phase |
| ready_in | input | 1 | Bus ready seen by all slaves; previous transfer done |
| ready_out | output | 1 | Slave ready; low inserts a wait state |
| resp | output | 1 | 0 OKAY, 1 ERROR |
| rdata | output | 32 | Read data, valid when ready_out is high |

## Verification
The bench builds the slave with WAIT_STATES=2, DEPTH=16 and BASE=0, and loops `ready_out` back to `ready_in` as a single-slave bus does. Two wait states make every legal data phase long enough to show that a held address phase is taken once and that the write data is sampled at the end of the phase. DEPTH=16 puts address 0x40 just past the window, where a truncated index would alias word 0, so an error write there shows whether the range check is missing.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_XFER = 2'd1,
    PH_ERR1 = 2'd2,
    PH_ERR2 = 2'd3
  } phase_t;

  // transfer type that carries data
  function automatic logic is_active(input logic [1:0] tr);
    return (tr == TR_NONSEQ) || (tr == TR_SEQ);
  endfunction

  // size may not exceed the bus width
  function automatic logic size_legal(input logic [2:0] sz);
    return sz <= 3'd2;
  endfunction

  // little-endian byte lanes touched by a transfer
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] sz,
                                                 input logic [1:0] off);
    logic [LANES-1:0] m;
    case (sz)
      3'd0:    m = 4'b0001 << off;
      3'd1:    m = off[1] ? 4'b1100 : 4'b0011;
      3'd2:    m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  // address lies in [base, base+span)
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [32:0] span);
    logic [32:0] off;
    off = {1'b0, a} - {1'b0, base};
    return !off[32] && (off < span);
  endfunction

endpackage

// File: rtl/wbs_decode.sv
module wbs_decode
  import wbs_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h0,
  parameter int          DEPTH = 16,
  parameter int          IDX_W = 4
) (
  input  logic [31:0]      addr,
  input  logic [2:0]       size,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic [LANES-1:0] mask
);
  localparam logic [32:0] SPAN = 33'(DEPTH * 4);

  logic [31:0] off;

  always_comb begin
    off  = addr - BASE;
    idx  = IDX_W'(off >> 2);
    hit  = in_window(addr, BASE, SPAN) && size_legal(size);
    mask = lane_mask(size, addr[1:0]);
  end
endmodule

// File: rtl/wbs_phase_ctrl.sv
module wbs_phase_ctrl
  import wbs_pkg::*;
#(
  parameter int WAIT_STATES = 1,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hit,
  input  logic             wr_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [LANES-1:0] mask_in,
  output phase_t           phase,
  output logic             ready_out,
  output logic             resp,
  output logic             cap_wr,
  output logic [IDX_W-1:0] cap_idx,
  output logic [LANES-1:0] cap_mask
);
  localparam int CNT_W = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_STATES);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (phase)
      PH_XFER: ready_out = (cnt == WAIT_LAST);
      PH_ERR1: ready_out = 1'b0;
      default: ready_out = 1'b1;
    endcase
    resp = (phase == PH_ERR1) || (phase == PH_ERR2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      cap_wr   <= 1'b0;
      cap_idx  <= '0;
      cap_mask <= '0;
    end else if (take) begin
      phase    <= hit ? PH_XFER : PH_ERR1;
      cnt      <= '0;
      cap_wr   <= wr_in & hit;
      cap_idx  <= idx_in;
      cap_mask <= mask_in;
    end else if (phase == PH_ERR1) begin
      phase <= PH_ERR2;
    end else if ((phase == PH_XFER) && !ready_out) begin
      cnt <= cnt + 1'b1;
    end else begin
      phase  <= PH_IDLE;
      cap_wr <= 1'b0;
    end
  end
endmodule

// File: rtl/wbs_lane_mem.sv
module wbs_lane_mem
  import wbs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] mask,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rword
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) bank[w] <= 8'h00;
      end else if (we && mask[g]) begin
        bank[idx] <= wdata[g*8 +: 8];
      end
    end

    assign rword[g*8 +: 8] = bank[idx];
  end
endmodule

// File: rtl/wait_bus_slave.sv
module wait_bus_slave
  import wbs_pkg::*;
#(
  parameter logic [31:0] BASE        = 32'h0,
  parameter int          DEPTH       = 16,
  parameter int          WAIT_STATES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic [31:0] addr,
  input  logic [1:0]  trans,
  input  logic        write,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  input  logic        ready_in,
  output logic        ready_out,
  output logic        resp,
  output logic [31:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // named internal events, used by the bound checker
  logic             addr_take;
  logic             commit_wr;
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [LANES-1:0] dec_mask;
  phase_t           phase;
  logic             cap_wr;
  logic [IDX_W-1:0] cap_idx;
  logic [LANES-1:0] cap_mask;
  logic [31:0]      rd_word;

  assign addr_take = sel && ready_in && is_active(trans);

  wbs_decode #(.BASE(BASE), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .size(size), .hit(dec_hit), .idx(dec_idx), .mask(dec_mask)
  );

  wbs_phase_ctrl #(.WAIT_STATES(WAIT_STATES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(addr_take), .hit(dec_hit),
    .wr_in(write), .idx_in(dec_idx), .mask_in(dec_mask),
    .phase(phase), .ready_out(ready_out), .resp(resp),
    .cap_wr(cap_wr), .cap_idx(cap_idx), .cap_mask(cap_mask)
  );

  assign commit_wr = (phase == PH_XFER) && ready_out && cap_wr;

  wbs_lane_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(commit_wr), .idx(cap_idx),
    .mask(cap_mask), .wdata(wdata), .rword(rd_word)
  );

  assign rdata = ((phase == PH_XFER) && !cap_wr) ? rd_word : 32'h0;
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
  parameter int WAIT_STATES = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ready_in,
  input logic ready_out,
  input logic resp,
  input logic addr_take,
  input logic commit_wr
);
  logic [2:0] low_ok_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_ok_run <= '0;
    else if (!ready_out && !resp) low_ok_run <= (low_ok_run == 3'd7) ? low_ok_run : low_ok_run + 3'd1;
    else                          low_ok_run <= '0;
  end

  // R2
  idle_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_in && !addr_take) |=> (ready_out && !resp));

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready_out) && !$past(addr_take)) |-> !commit_wr);

  // R3
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ready_out && !resp) || (int'(low_ok_run) < WAIT_STATES));

  // R3
  first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_take |=> (resp || (ready_out == (WAIT_STATES == 0))));

  // R6
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp && !ready_out) |=> (resp && ready_out));

  // R6
  err_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp) |-> !ready_out);

  // R7
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |-> !resp);
endmodule

bind wait_bus_slave wbs_checker #(.WAIT_STATES(WAIT_STATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .ready_out(ready_out),
  .resp(resp), .addr_take(addr_take), .commit_wr(commit_wr)
);

// File: tb/wait_bus_slave_test.sv
module wait_bus_slave_test;
  localparam int WAITS = 2;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        write = 1'b0;
  logic [2:0]  size = 3'd2;
  logic [31:0] wdata = '0;
  logic        ready_out;
  logic        resp;
  logic [31:0] rdata;

  always #4 clk = ~clk;

  wait_bus_slave #(.BASE(32'h0), .DEPTH(DEPTH), .WAIT_STATES(WAITS)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .trans(trans),
    .write(write), .size(size), .wdata(wdata), .ready_in(ready_out),
    .ready_out(ready_out), .resp(resp), .rdata(rdata)
  );

  typedef struct {
    bit          err;
    bit          is_rd;
    int          waits;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t       sbq[$];
  item_t       cur;
  logic [31:0] model [DEPTH];
  int          vectors = 0;
  int          miscompares = 0;
  bit          ap_item = 1'b0;
  bit          in_dp = 1'b0;
  int          waits_seen = 0;
  bit          done = 1'b0;

  task automatic report_fail(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // driver: presents one address phase, pushes the expected result
  task automatic issue(input logic s, input logic [1:0] tr, input logic w,
                       input logic [2:0] sz, input logic [31:0] a,
                       input logic [31:0] d, input string tag);
    item_t it;
    bit act, ok;
    sel = s; trans = tr; write = w; size = sz; addr = a; ap_item = 1'b1;
    act = s && tr[1];
    ok  = act && (a < 32'(DEPTH * 4)) && (sz <= 3'd2);
    it.err   = act && !ok;
    it.waits = !act ? 0 : (ok ? WAITS : 1);
    it.is_rd = ok && !w;
    it.data  = model[a[5:2]];
    it.tag   = tag;
    if (ok && w) begin
      for (int k = 0; k < 4; k++) begin
        bit hitk;
        hitk = (sz == 3'd2) || (sz == 3'd1 && k[1] == a[1]) ||
               (sz == 3'd0 && k == int'(a[1:0]));
        if (hitk) model[a[5:2]][k*8 +: 8] = d[k*8 +: 8];
      end
    end
    sbq.push_back(it);
    while (!ready_out) @(negedge clk);
    @(negedge clk);
    wdata = d;
    ap_item = 1'b0; sel = 1'b0; trans = 2'b00; write = 1'b0;
  endtask

  // monitor: checks each data phase as it finishes
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (in_dp) begin
        if (!ready_out) begin
          waits_seen++;
          if (resp !== cur.err) begin
            vectors++;
            report_fail(cur.tag, "resp during wait", 32'(resp), 32'(cur.err));
          end
        end else begin
          vectors++;
          if (waits_seen != cur.waits || resp !== cur.err ||
              (cur.is_rd && rdata !== cur.data)) begin
            if (waits_seen != cur.waits)
              report_fail(cur.tag, "wait count", 32'(waits_seen), 32'(cur.waits));
            else if (resp !== cur.err)
              report_fail(cur.tag, "resp", 32'(resp), 32'(cur.err));
            else
              report_fail(cur.tag, "rdata", rdata, cur.data);
          end
          in_dp = 1'b0;
        end
      end
      if (ready_out && ap_item && sbq.size() > 0) begin
        cur = sbq.pop_front();
        in_dp = 1'b1;
        waits_seen = 0;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    vectors++;
    if (ready_out !== 1'b1 || resp !== 1'b0 || rdata !== 32'h0)
      report_fail("R1", "reset outputs", {ready_out, resp, rdata[29:0]}, 32'h8000_0000);

    // R3 R4 back-to-back word writes (NONSEQ then SEQ)
    issue(1, 2'b10, 1, 3'd2, 32'h00, 32'h1111_0000, "R3");
    issue(1, 2'b11, 1, 3'd2, 32'h04, 32'h2222_0001, "R4");
    issue(1, 2'b11, 1, 3'd2, 32'h08, 32'h3333_0002, "R4");
    issue(1, 2'b11, 1, 3'd2, 32'h0C, 32'h4444_0003, "R4");
    // R5 R8 back-to-back reads
    issue(1, 2'b10, 0, 3'd2, 32'h00, 32'h0, "R5");
    issue(1, 2'b11, 0, 3'd2, 32'h04, 32'h0, "R8");
    issue(1, 2'b11, 0, 3'd2, 32'h08, 32'h0, "R5");
    issue(1, 2'b11, 0, 3'd2, 32'h0C, 32'h0, "R8");
    // R4 byte lanes of word 4, then halfwords of word 5
    issue(1, 2'b10, 1, 3'd0, 32'h10, 32'h0000_00A1, "R4");
    issue(1, 2'b10, 1, 3'd0, 32'h13, 32'hD4FF_FFFF, "R4");
    issue(1, 2'b10, 1, 3'd0, 32'h11, 32'hFFFF_B2FF, "R4");
    issue(1, 2'b10, 0, 3'd2, 32'h10, 32'h0, "R4");
    issue(1, 2'b10, 1, 3'd2, 32'h14, 32'h5555_5555, "R4");
    issue(1, 2'b10, 1, 3'd1, 32'h16, 32'hBEEF_0000, "R4");
    issue(1, 2'b10, 1, 3'd1, 32'h14, 32'h1234_CAFE, "R4");
    issue(1, 2'b10, 0, 3'd2, 32'h14, 32'h0, "R4");
    // R8 write then read of the same word
    issue(1, 2'b10, 1, 3'd2, 32'h20, 32'hA5A5_5A5A, "R8");
    issue(1, 2'b10, 0, 3'd2, 32'h20, 32'h0, "R8");
    // R2 idle and busy with write high, sel low write
    issue(1, 2'b00, 1, 3'd2, 32'h00, 32'hDEAD_0000, "R2");
    issue(1, 2'b01, 1, 3'd2, 32'h04, 32'hDEAD_0001, "R2");
    issue(0, 2'b10, 1, 3'd2, 32'h08, 32'hDEAD_0002, "R2");
    issue(1, 2'b10, 0, 3'd2, 32'h00, 32'h0, "R2");
    issue(1, 2'b10, 0, 3'd2, 32'h04, 32'h0, "R2");
    issue(1, 2'b10, 0, 3'd2, 32'h08, 32'h0, "R2");
    // R6 out of range write (would alias word 0) and read
    issue(1, 2'b10, 1, 3'd2, 32'h40, 32'hBAD0_0000, "R6");
    issue(1, 2'b10, 0, 3'd2, 32'h0000_1000, 32'h0, "R6");
    issue(1, 2'b10, 0, 3'd2, 32'h00, 32'h0, "R6");
    // R7 oversize write then read back
    issue(1, 2'b10, 1, 3'd3, 32'h0C, 32'hBAD0_0003, "R7");
    issue(1, 2'b10, 0, 3'd2, 32'h0C, 32'h0, "R7");
    // R8 error followed at once by a legal read
    issue(1, 2'b10, 1, 3'd2, 32'h44, 32'hBAD0_0004, "R8");
    issue(1, 2'b10, 0, 3'd2, 32'h20, 32'h0, "R8");

    repeat (8) @(negedge clk);
    vectors++;
    if (sbq.size() != 0 || in_dp)
      report_fail("R8", "items left", 32'(sbq.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule